// File: doc/BRIEF.md
# Transmit Interrupt Mitigation Timer

This block cuts down the number of interrupts a network controller raises for outgoing traffic. It counts successful transmit completions in an unbroken run. The completion interrupt is raised only when that run reaches a burst count that software programs. A failed transmission ends the run, and counting starts again from zero.

A second mechanism watches for an idle transmitter. Each time a transmit starts, a countdown is loaded from a programmed timeout. The timeout value is meant to cover the deferral time plus the back-off time. A prescaler divides the system clock into a tick, and the tick period depends on the selected link speed: 2.56 us per tick on the fast link and 25.6 us per tick on the slow one. The countdown moves only while a separate enable input is high. If it reaches zero before the next transmit starts, an idle interrupt is raised.

Both settings live in one 32-bit configuration word. Software writes the word and can read it back.

Top module: `txint_mitigator`

## Requirements
- R1: Configuration layout. The burst count is bits 20..16 (5 bits) and the timeout is bits 11..0 (12 bits). Every other bit reads as zero. After reset `cfg_rd_data` is 0, and a write shows in `cfg_rd_data` on the cycle after the write edge.
- R2: With a burst count N of 2 or more, `txc_irq` is high for one cycle, the cycle after the edge that samples the N-th consecutive `tx_done_ok`. Counting then restarts from zero.
- R3: `tx_done_err` clears the run of successes. If it arrives in the same cycle as `tx_done_ok`, the error wins and no interrupt is raised.
- R4: A burst count of 0 or 1 raises `txc_irq` after every successful completion.
- R5: On the fast link (`speed_fast`=1) with a timeout T>0 and the enable held high, `idle_irq` is high for exactly one cycle. That cycle follows the edge that is T*DIV_FAST edges after the edge that sampled `tx_start`.
- R6: On the slow link (`speed_fast`=0) the same expiry occurs T*DIV_SLOW edges after the start.
- R7: A `tx_start` before expiry reloads the countdown and restarts the tick phase. No interrupt comes from the abandoned countdown.
- R8: While `idle_irq_en` is low the countdown is frozen and `idle_irq` stays low. When the enable is raised again, the countdown resumes.
- R9: The idle interrupt fires once per expiry and not again until the next `tx_start`. A timeout of 0 never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration word |
| cfg_wr_data | input | 32 | Configuration write data |
| cfg_rd_data | output | 32 | Configuration read-back; reserved bits are zero |
| idle_irq_en | input | 1 | Lets the idle countdown run |
| speed_fast | input | 1 | 1 selects the fast-link tick, 0 the slow-link tick |
| tx_start | input | 1 | One-cycle pulse when a transmit begins |
| tx_done_ok | input | 1 | One-cycle pulse for a successful completion |
| tx_done_err | input | 1 | One-cycle pulse for a failed completion |
| txc_irq | output | 1 | Coalesced transmit-complete interrupt pulse |
| idle_irq | output | 1 | Idle-timeout interrupt pulse |

## Verification
The bench targets the boundaries of the success run:
- An interrupt on the N-th success and never on the (N-1)-th catches an off-by-one compare.
- An error in the middle of a run, and an error together with a success, catch a design that only pauses the run, or lets the success win.
- Burst counts of 0 and 1 catch a design that divides by zero or waits for 32 completions.

For the timer, the bench checks the exact expiry cycle at both link speeds, which exposes a swapped prescaler or a tick that is off by one. A restart just before expiry exposes a countdown that does not reload. A frozen enable, a second silent expiry window and a zero timeout expose an interrupt that repeats or fires without being armed.

// File: rtl/txm_pkg.sv
package txm_pkg;
  localparam int BURST_W   = 5;
  localparam int BURST_LSB = 16;
  localparam int TMO_W     = 12;
  localparam int TMO_LSB   = 0;
  localparam logic [31:0] CFG_MASK =
    ({{(32-BURST_W){1'b0}}, {BURST_W{1'b1}}} << BURST_LSB) |
    ({{(32-TMO_W){1'b0}}, {TMO_W{1'b1}}} << TMO_LSB);

  typedef struct packed {
    logic [BURST_W-1:0] burst;
    logic [TMO_W-1:0]   timeout;
  } txm_cfg_t;
endpackage

// File: rtl/txm_cfg_reg.sv
module txm_cfg_reg
  import txm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output txm_cfg_t    cfg,
  output logic [31:0] rd_data
);
  txm_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d.burst   = wr_data[BURST_LSB +: BURST_W];
      cfg_d.timeout = wr_data[TMO_LSB +: TMO_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  always_comb begin
    rd_data = '0;
    rd_data[BURST_LSB +: BURST_W] = cfg_q.burst;
    rd_data[TMO_LSB +: TMO_W]     = cfg_q.timeout;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/txm_tick_gen.sv
module txm_tick_gen #(
  parameter int DIV_FAST = 256,
  parameter int DIV_SLOW = 2560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic speed_fast,
  output logic tick
);
  localparam int DIV_MAX = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
  localparam int PW      = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1;
  localparam logic [PW-1:0] LOAD_FAST = PW'(DIV_FAST - 1);
  localparam logic [PW-1:0] LOAD_SLOW = PW'(DIV_SLOW - 1);

  logic [PW-1:0] pcnt_q, pcnt_d;
  logic [PW-1:0] load_val;

  assign load_val = speed_fast ? LOAD_FAST : LOAD_SLOW;
  assign tick     = (pcnt_q == '0);

  always_comb begin
    if (restart)   pcnt_d = load_val;
    else if (tick) pcnt_d = load_val;
    else           pcnt_d = pcnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= LOAD_FAST;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/txm_burst_coalescer.sv
module txm_burst_coalescer
  import txm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               done_ok,
  input  logic               done_err,
  input  logic [BURST_W-1:0] burst,
  output logic               irq
);
  logic [BURST_W-1:0] run_q, run_d;
  logic               irq_q, irq_d;
  logic [BURST_W:0]   run_next;
  logic [BURST_W:0]   target;

  assign run_next = {1'b0, run_q} + 1'b1;
  assign target   = (burst == '0) ? (BURST_W+1)'(1) : {1'b0, burst};

  always_comb begin
    run_d = run_q;
    irq_d = 1'b0;
    if (done_err) begin
      run_d = '0;
    end else if (done_ok) begin
      if (run_next >= target) begin
        run_d = '0;
        irq_d = 1'b1;
      end else begin
        run_d = run_next[BURST_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      irq_q <= 1'b0;
    end else begin
      run_q <= run_d;
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/txm_idle_timer.sv
module txm_idle_timer
  import txm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             enable,
  input  logic             tick,
  input  logic [TMO_W-1:0] timeout,
  output logic             irq
);
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             irq_q, irq_d;
  logic             step_en;

  assign step_en = armed_q && enable && tick;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    irq_d   = 1'b0;
    if (start) begin
      cnt_d   = timeout;
      armed_d = (timeout != '0);
    end else if (step_en) begin
      if (cnt_q <= TMO_W'(1)) begin
        cnt_d   = '0;
        armed_d = 1'b0;
        irq_d   = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      irq_q   <= irq_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/txint_mitigator.sv
module txint_mitigator
  import txm_pkg::*;
#(
  parameter int DIV_FAST = 256,
  parameter int DIV_SLOW = 2560
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr_en,
  input  logic [31:0] cfg_wr_data,
  output logic [31:0] cfg_rd_data,
  input  logic        idle_irq_en,
  input  logic        speed_fast,
  input  logic        tx_start,
  input  logic        tx_done_ok,
  input  logic        tx_done_err,
  output logic        txc_irq,
  output logic        idle_irq
);
  txm_cfg_t cfg;
  logic     tick;

  txm_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .cfg     (cfg),
    .rd_data (cfg_rd_data)
  );

  txm_tick_gen #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (tx_start),
    .speed_fast (speed_fast),
    .tick       (tick)
  );

  txm_burst_coalescer u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .done_ok  (tx_done_ok),
    .done_err (tx_done_err),
    .burst    (cfg.burst),
    .irq      (txc_irq)
  );

  txm_idle_timer u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tx_start),
    .enable  (idle_irq_en),
    .tick    (tick),
    .timeout (cfg.timeout),
    .irq     (idle_irq)
  );
endmodule

// File: rtl/txint_mitigator_chk.sv
module txint_mitigator_chk
  import txm_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr_en,
  input logic [31:0] cfg_wr_data,
  input logic [31:0] cfg_rd_data,
  input logic        idle_irq_en,
  input logic        tx_start,
  input logic        tx_done_ok,
  input logic        tx_done_err,
  input logic        txc_irq,
  input logic        idle_irq
);
  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data & ~CFG_MASK) == 32'd0);

  p_write_visible_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> (cfg_rd_data == ($past(cfg_wr_data) & CFG_MASK)));

  p_txc_after_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txc_irq) |-> $past(tx_done_ok));

  p_err_blocks_txc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_err |=> !txc_irq);

  p_start_blocks_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !idle_irq);

  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_irq_en |=> !idle_irq);

  p_idle_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idle_irq |=> !idle_irq);
endmodule

bind txint_mitigator txint_mitigator_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_wr_data (cfg_wr_data),
  .cfg_rd_data (cfg_rd_data),
  .idle_irq_en (idle_irq_en),
  .tx_start    (tx_start),
  .tx_done_ok  (tx_done_ok),
  .tx_done_err (tx_done_err),
  .txc_irq     (txc_irq),
  .idle_irq    (idle_irq)
);

// File: tb/txint_mitigator_tb_top.sv
module txint_mitigator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_F      = 4;
  localparam int DIV_S      = 40;
  localparam int NVEC       = 13;

  // each vector: {tx_done_ok, tx_done_err, expected txc_irq}, burst count = 3
  localparam logic [2:0] VEC [NVEC] = '{
    3'b100, 3'b100, 3'b101, 3'b000, 3'b100, 3'b010, 3'b100,
    3'b100, 3'b101, 3'b110, 3'b100, 3'b100, 3'b101
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [31:0] cfg_wr_data;
  logic [31:0] cfg_rd_data;
  logic        idle_irq_en;
  logic        speed_fast;
  logic        tx_start;
  logic        tx_done_ok;
  logic        tx_done_err;
  logic        txc_irq;
  logic        idle_irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txint_mitigator #(.DIV_FAST(DIV_F), .DIV_SLOW(DIV_S)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .cfg_wr_en (cfg_wr_en), .cfg_wr_data (cfg_wr_data), .cfg_rd_data (cfg_rd_data),
    .idle_irq_en (idle_irq_en), .speed_fast (speed_fast),
    .tx_start (tx_start), .tx_done_ok (tx_done_ok), .tx_done_err (tx_done_err),
    .txc_irq (txc_irq), .idle_irq (idle_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic [31:0] d);
    cfg_wr_en = 1'b1; cfg_wr_data = d; step();
    cfg_wr_en = 1'b0; cfg_wr_data = '0;
  endtask

  task automatic pulse_start();
    tx_start = 1'b1; step(); tx_start = 1'b0;
  endtask

  // after pulse_start: idle_irq must be high exactly after edge number `at`
  task automatic idle_window(input string req, input int at, input int len);
    for (int i = 1; i <= len; i++) begin
      step();
      check(req, {31'd0, idle_irq}, {31'd0, (i == at)});
    end
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0; idle_irq_en = 1'b0;
    speed_fast = 1'b1; tx_start = 1'b0; tx_done_ok = 1'b0; tx_done_err = 1'b0;
    repeat (3) step();
    check("R1 reset rd", cfg_rd_data, 32'd0);
    check("R1 reset irq", {30'd0, txc_irq, idle_irq}, 32'd0);
    rst_n = 1'b1;
    step();

    // R1: reserved bits read as zero
    write_cfg(32'hFFFF_FFFF);
    check("R1 mask", cfg_rd_data, 32'h001F_0FFF);
    write_cfg(32'h0003_0000);
    check("R1 layout", cfg_rd_data, 32'h0003_0000);

    // R2 and R3 table, burst 3
    for (int v = 0; v < NVEC; v++) begin
      tx_done_ok = VEC[v][2]; tx_done_err = VEC[v][1];
      step();
      tx_done_ok = 1'b0; tx_done_err = 1'b0;
      check($sformatf("R2 R3 vector %0d", v), {31'd0, txc_irq}, {31'd0, VEC[v][0]});
    end

    // R4: burst 0 and 1 -> every success
    write_cfg(32'h0000_0000);
    for (int k = 0; k < 3; k++) begin
      tx_done_ok = 1'b1; step(); tx_done_ok = 1'b0;
      check("R4 burst0", {31'd0, txc_irq}, 32'd1);
      step();
      check("R4 burst0 gap", {31'd0, txc_irq}, 32'd0);
    end
    write_cfg(32'h0001_0000);
    tx_done_ok = 1'b1; step(); tx_done_ok = 1'b0;
    check("R4 burst1", {31'd0, txc_irq}, 32'd1);

    // R5: fast link, T=3 -> 12 edges; R9: no repeat afterwards
    idle_irq_en = 1'b1; speed_fast = 1'b1;
    write_cfg(32'h0000_0003);
    pulse_start();
    idle_window("R5 R9 fast", 3*DIV_F, 3*DIV_F + 20);

    // R6: slow link, T=2 -> 80 edges
    speed_fast = 1'b0;
    write_cfg(32'h0000_0002);
    pulse_start();
    idle_window("R6 slow", 2*DIV_S, 2*DIV_S + 10);

    // R7: restart before expiry
    speed_fast = 1'b1;
    write_cfg(32'h0000_0003);
    pulse_start();
    idle_window("R7 before restart", 0, 3*DIV_F - 1);
    pulse_start();
    idle_window("R7 after restart", 3*DIV_F, 3*DIV_F + 5);

    // R8: frozen while disabled, resumes after enable
    pulse_start();
    idle_irq_en = 1'b0;
    idle_window("R8 disabled", 0, 60);
    idle_irq_en = 1'b1;
    begin
      int seen = 0;
      for (int i = 0; i < 3*DIV_F + DIV_F + 4; i++) begin
        step();
        if (idle_irq) seen++;
      end
      check("R8 resume count", seen, 32'd1);
    end

    // R9: zero timeout never fires
    write_cfg(32'h0000_0000);
    pulse_start();
    idle_window("R9 zero timeout", 0, 40);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule